// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns per-channel audio samples into one serial data line, a frame-sync line and a bit strobe. It runs on the system clock. A one-cycle `bit_tick` input stands for each bit-clock period, and every output bit is produced on a tick. The frame can be two-channel I2S, two-channel left-justified, TDM with one-bit data delay, or TDM with no delay. The format is chosen at the start of each frame from the configuration inputs. The configuration also sets the sample length, a narrow-slot option, the TDM slot count, the width of the TDM frame-sync pulse, mono duplication and what to send when a channel has no data.

Each channel has a holding register with a valid/ready handshake. When a slot begins, the transmitter moves the sample of that slot's channel into the shifter and raises a one-cycle loaded flag for that channel. If the holding register is empty, the transmitter raises a one-cycle underrun flag and sends a fill word instead. Slot k always carries channel k. In the two-channel formats, slot 0 is the left channel (channel 0) and slot 1 is the right channel (channel 1).

Top module: `aud_tx_top`

## Requirements
- R1: After reset, `sd_out`, `fs_out`, `bit_stb`, `ch_loaded` and `ch_underrun` are all low and every bit of `s_ready` is high.
- R2: With `cfg_fmt` 0 (I2S) or 2 (TDM), `sd_out` carries each bit one tick after its frame position, so the sample MSB follows the frame-sync edge by one bit. With `cfg_fmt` 1 (left-justified) or 3 (TDM left-justified), the MSB goes out on the same tick as the edge. In delayed formats, the first bit of a frame carries the last bit of the previous frame.
- R3: `cfg_len` selects the sample width as follows: 0=32, 1=24, 2=20, 3=18, 4 and 5=16, 6 and 7=8. The sample is taken from the low bits of the 32-bit holding word and sent MSB first. The slot bits after the sample are zeros.
- R4: In formats 0 and 1 the slot width is 32 bits for code 0, and 16 or 8 bits for codes 4–7. For codes 1–3 it is 32 bits, or 24 bits when `cfg_narrow` is 1.
- R5: In formats 2 and 3 every slot is 32 bits wide, and a frame has `cfg_slots_m1`+1 slots.
- R6: In formats 0 and 1, `fs_out` is low for every bit position of slot 0 and high for every bit position of slot 1.
- R7: In formats 2 and 3, `fs_out` is high from frame position 0. With `cfg_fs_width` 0 it stays high for one slot (32 bits). With 1 it stays high for half the frame (slots×16 bits). With 2 or 3 it is high for position 0 only.
- R8: A slot that starts with an empty holding register pulses that channel's `ch_underrun` for one cycle. It sends zeros when `cfg_repeat` is 0, and the channel's last loaded sample when `cfg_repeat` is 1. At most one loaded or underrun flag is high in any cycle.
- R9: With `cfg_mono` 1, every odd slot repeats the word of the slot before it. The odd channel's holding register is not read, and that channel raises no flag.
- R10: `s_ready[c]` is high while holding register c is empty. A cycle with `s_valid[c]` and `s_ready[c]` stores the word and drops `s_ready[c]`. Moving the word into the shifter pulses `ch_loaded[c]` and raises `s_ready[c]` again.
- R11: The configuration is sampled only at frame position 0. Changes in the middle of a frame take effect at the next frame.
- R12: `bit_stb` pulses one cycle after each `bit_tick`. `sd_out`, `fs_out` and the flags change only on the clock edge that consumes a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit-clock period |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 TDM, 3 TDM left-justified |
| cfg_len | input | 3 | Sample-length code |
| cfg_narrow | input | 1 | 24-bit slots for 18/20/24-bit samples in two-channel formats |
| cfg_slots_m1 | input | 3 | TDM slot count minus one |
| cfg_fs_width | input | 2 | TDM frame-sync width: 0 slot, 1 half frame, 2/3 one bit |
| cfg_mono | input | 1 | Copy each even slot into the following odd slot |
| cfg_repeat | input | 1 | Underrun fill: 0 zeros, 1 last loaded sample |
| s_valid | input | NCH | Per-channel sample valid |
| s_data | input | NCH*DW | Per-channel sample words, channel c at bits c*DW+:DW |
| s_ready | output | NCH | Per-channel holding register empty |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync |
| bit_stb | output | 1 | Marks the cycle after a tick, when new outputs are present |
| ch_loaded | output | NCH | One-cycle pulse: channel sample moved into the shifter |
| ch_underrun | output | NCH | One-cycle pulse: slot started with no sample |

## Verification
The bench sweeps every format, every length code and both narrow settings. It varies the TDM slot count and frame-sync width between runs and rebuilds each frame bit by bit from arithmetic. Several cases need exact framing to pass:
- A full 32-bit sample in a delayed format puts its LSB into position 0 of the next frame. A design that drops or restarts the delay line would lose that bit.
- A half-frame sync with an odd slot count ends in the middle of a slot. An off-by-one compare would shift that edge.
- Mono mode must leave the odd channel's holding register full. A design that consumed it would raise `s_ready` and a loaded flag.
- A configuration change in the middle of a frame must not disturb the frame already in progress, but must fully govern the next one.

Underrun runs check both fill policies across consecutive frames, with the flags on the right channel.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TDM_SLOT_W = 32;

  typedef struct packed {
    logic [1:0] fmt;
    logic [2:0] len;
    logic       narrow;
    logic [2:0] slots_m1;
    logic [1:0] fs_width;
    logic       mono;
    logic       repeat_fill;
  } tx_cfg_t;

  function automatic logic [5:0] sample_bits(input logic [2:0] code);
    case (code)
      3'd0:       sample_bits = 6'd32;
      3'd1:       sample_bits = 6'd24;
      3'd2:       sample_bits = 6'd20;
      3'd3:       sample_bits = 6'd18;
      3'd4, 3'd5: sample_bits = 6'd16;
      default:    sample_bits = 6'd8;
    endcase
  endfunction

  function automatic logic [5:0] slot_bits(input tx_cfg_t c);
    if (c.fmt[1]) slot_bits = 6'(TDM_SLOT_W);
    else begin
      case (c.len)
        3'd0:             slot_bits = 6'd32;
        3'd1, 3'd2, 3'd3: slot_bits = c.narrow ? 6'd24 : 6'd32;
        3'd4, 3'd5:       slot_bits = 6'd16;
        default:          slot_bits = 6'd8;
      endcase
    end
  endfunction

  function automatic logic [3:0] slot_count(input tx_cfg_t c);
    slot_count = c.fmt[1] ? ({1'b0, c.slots_m1} + 4'd1) : 4'd2;
  endfunction

  // Move the low sample bits to the top of the word; lower bits become zero.
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] d,
                                                  input logic [2:0] code);
    msb_align = d << (6'(WORD_W) - sample_bits(code));
  endfunction
endpackage

// File: rtl/aud_tx_frame.sv
module aud_tx_frame #(
  parameter int unsigned SLOT_IDX_W = 3,
  parameter int unsigned BIT_IDX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic [BIT_IDX_W-1:0]  slot_len,
  input  logic [SLOT_IDX_W:0]   n_slots,
  input  logic                  tdm,
  input  logic [1:0]            fs_width,
  output logic [SLOT_IDX_W-1:0] slot_q,
  output logic [BIT_IDX_W-1:0]  bit_q,
  output logic                  frame_start,
  output logic                  fs_next
);
  localparam int unsigned POS_W = SLOT_IDX_W + 6;

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] half;
  logic             last_bit;
  logic             last_slot;

  assign frame_start = (slot_q == '0) && (bit_q == '0);
  assign last_bit    = (bit_q == slot_len - 1'b1);
  assign last_slot   = ({1'b0, slot_q} == n_slots - 1'b1);
  assign pos         = POS_W'({slot_q, 5'b0}) + POS_W'(bit_q);
  assign half        = POS_W'({n_slots, 4'b0});

  always_comb begin
    if (!tdm) fs_next = slot_q[0];
    else begin
      case (fs_width)
        2'd0:    fs_next = (slot_q == '0);
        2'd1:    fs_next = (pos < half);
        default: fs_next = frame_start;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (tick) begin
      if (last_bit) begin
        bit_q  <= '0;
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aud_tx_hold.sv
module aud_tx_hold #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          wr_valid,
  input  logic [NCH-1:0][DW-1:0]  wr_data,
  input  logic [NCH-1:0]          take,
  output logic [NCH-1:0]          full,
  output logic [NCH-1:0][DW-1:0]  data,
  output logic [NCH-1:0][DW-1:0]  last
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        full[c] <= 1'b0;
        data[c] <= '0;
        last[c] <= '0;
      end else if (take[c]) begin
        full[c] <= 1'b0;
        last[c] <= data[c];
      end else if (wr_valid[c] && !full[c]) begin
        full[c] <= 1'b1;
        data[c] <= wr_data[c];
      end
    end
  end
endmodule

// File: rtl/aud_tx_top.sv
module aud_tx_top
  import aud_tx_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [1:0]        cfg_fmt,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_narrow,
  input  logic [2:0]        cfg_slots_m1,
  input  logic [1:0]        cfg_fs_width,
  input  logic              cfg_mono,
  input  logic              cfg_repeat,
  input  logic [NCH-1:0]    s_valid,
  input  logic [NCH*DW-1:0] s_data,
  output logic [NCH-1:0]    s_ready,
  output logic              sd_out,
  output logic              fs_out,
  output logic              bit_stb,
  output logic [NCH-1:0]    ch_loaded,
  output logic [NCH-1:0]    ch_underrun
);
  localparam int unsigned SIW = $clog2(NCH);

  tx_cfg_t cfg_in, cfg_q, eff;
  logic [SIW-1:0] slot_q;
  logic [5:0]     bit_q;
  logic           frame_start, fs_next, slot_start, mono_copy, have;
  logic [NCH-1:0] full, take, miss;
  logic [NCH-1:0][DW-1:0] hdata, hlast;
  logic [DW-1:0]  fresh, word_now, shift_q, prev_word;
  logic           lj_q;

  assign cfg_in = '{fmt: cfg_fmt, len: cfg_len, narrow: cfg_narrow,
                    slots_m1: cfg_slots_m1, fs_width: cfg_fs_width,
                    mono: cfg_mono, repeat_fill: cfg_repeat};
  assign eff = frame_start ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (bit_tick && frame_start) cfg_q <= cfg_in;
  end

  aud_tx_frame #(.SLOT_IDX_W(SIW), .BIT_IDX_W(6)) u_frame (
    .clk(clk), .rst(rst), .tick(bit_tick),
    .slot_len(slot_bits(eff)), .n_slots(slot_count(eff)),
    .tdm(eff.fmt[1]), .fs_width(eff.fs_width),
    .slot_q(slot_q), .bit_q(bit_q), .frame_start(frame_start), .fs_next(fs_next)
  );

  aud_tx_hold #(.NCH(NCH), .DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr_valid(s_valid), .wr_data(s_data), .take(take),
    .full(full), .data(hdata), .last(hlast)
  );

  assign s_ready    = ~full;
  assign slot_start = (bit_q == '0);
  assign mono_copy  = eff.mono && slot_q[0];
  assign have       = full[slot_q];

  always_comb begin
    if (mono_copy)             fresh = prev_word;
    else if (have)             fresh = msb_align(hdata[slot_q], eff.len);
    else if (eff.repeat_fill)  fresh = msb_align(hlast[slot_q], eff.len);
    else                       fresh = '0;
  end

  assign word_now = slot_start ? fresh : shift_q;

  always_comb begin
    take = '0;
    miss = '0;
    if (bit_tick && slot_start && !mono_copy) begin
      if (have) take[slot_q] = 1'b1;
      else      miss[slot_q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q     <= '0;
      prev_word   <= '0;
      lj_q        <= 1'b0;
      sd_out      <= 1'b0;
      fs_out      <= 1'b0;
      bit_stb     <= 1'b0;
      ch_loaded   <= '0;
      ch_underrun <= '0;
    end else begin
      bit_stb     <= bit_tick;
      ch_loaded   <= take;
      ch_underrun <= miss;
      if (bit_tick) begin
        shift_q <= word_now << 1;
        if (slot_start) prev_word <= fresh;
        lj_q    <= word_now[DW-1];
        sd_out  <= eff.fmt[0] ? word_now[DW-1] : lj_q;
        fs_out  <= fs_next;
      end
    end
  end
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_tick,
  input logic [NCH-1:0] s_valid,
  input logic [NCH-1:0] s_ready,
  input logic           sd_out,
  input logic           fs_out,
  input logic [NCH-1:0] ch_loaded,
  input logic [NCH-1:0] ch_underrun
);
  p_flag_after_tick_r12: assert property (@(posedge clk) disable iff (rst)
    (|(ch_loaded | ch_underrun)) |-> $past(bit_tick));

  p_lines_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> ($stable(sd_out) && $stable(fs_out)));

  p_single_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_loaded | ch_underrun));

  p_load_frees_r10: assert property (@(posedge clk) disable iff (rst)
    (ch_loaded & ~s_ready) == '0);

  p_accept_fills_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(s_valid & s_ready) & s_ready) == '0));
endmodule

bind aud_tx_top aud_tx_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .s_valid(s_valid),
  .s_ready(s_ready), .sd_out(sd_out), .fs_out(fs_out),
  .ch_loaded(ch_loaded), .ch_underrun(ch_underrun)
);

// File: tb/tb_aud_tx_top.sv
`timescale 1ns/1ps
module tb_aud_tx_top;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic clk = 1'b0, rst = 1'b1, bit_tick = 1'b0;
  logic [1:0] cfg_fmt = '0, cfg_fs_width = '0;
  logic [2:0] cfg_len = '0, cfg_slots_m1 = '0;
  logic cfg_narrow = 1'b0, cfg_mono = 1'b0, cfg_repeat = 1'b0;
  logic [NCH-1:0] s_valid = '0;
  logic [NCH*DW-1:0] s_data = '0;
  logic [NCH-1:0] s_ready, ch_loaded, ch_underrun;
  logic sd_out, fs_out, bit_stb;

  always #2.5 clk = ~clk;

  aud_tx_top #(.NCH(NCH), .DW(DW)) dut (.*);

  int checks = 0, errors = 0;
  int cf_fmt, cf_len, cf_nar, cf_sm1, cf_fsw, cf_mono, cf_rep;
  logic [31:0] last_sent [NCH];
  logic [31:0] wdata [NCH];
  bit wrote [NCH];
  bit prev_lj;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lenb(int c);
    case (c) 0: return 32; 1: return 24; 2: return 20; 3: return 18;
      4, 5: return 16; default: return 8; endcase
  endfunction

  function automatic int sbits();
    if (cf_fmt >= 2) return 32;
    case (cf_len) 0: return 32; 1, 2, 3: return cf_nar ? 24 : 32;
      4, 5: return 16; default: return 8; endcase
  endfunction

  function automatic int nslots();
    return (cf_fmt >= 2) ? cf_sm1 + 1 : 2;
  endfunction

  function automatic logic [31:0] algn(logic [31:0] d);
    return d << (32 - lenb(cf_len));
  endfunction

  task automatic reset_dut();
    rst = 1'b1; bit_tick = 1'b0; s_valid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prev_lj = 1'b0;
    for (int c = 0; c < NCH; c++) begin last_sent[c] = '0; wrote[c] = 0; end
  endtask

  task automatic set_cfg(int f, int l, int n, int s, int w, int m, int r);
    @(negedge clk);
    cf_fmt = f; cf_len = l; cf_nar = n; cf_sm1 = s; cf_fsw = w; cf_mono = m; cf_rep = r;
    cfg_fmt = 2'(f); cfg_len = 3'(l); cfg_narrow = n[0]; cfg_slots_m1 = 3'(s);
    cfg_fs_width = 2'(w); cfg_mono = m[0]; cfg_repeat = r[0];
  endtask

  task automatic write_ch(logic [NCH-1:0] mask, int seed);
    @(negedge clk);
    s_valid = mask;
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] d;
      d = (32'h9E3779B9 * 32'(c + 1 + seed * 8)) ^ 32'h5A5A0F0F;
      s_data[c*DW +: DW] = d;
      if (mask[c]) begin wdata[c] = d; wrote[c] = 1; end
    end
    @(negedge clk);
    s_valid = '0;
    chk((s_ready & mask) == '0, "R10", "ready low after store", s_ready, ~mask);
  endtask

  task automatic run_frame(input bit midchange, input string tsd, input string tfs);
    int sb, ns, F, sd_err, fs_err, st_err, fl_err;
    logic [31:0] ew [NCH];
    int exp_ld [NCH], exp_ur [NCH], ld [NCH], ur [NCH];
    logic [NCH-1:0] exp_rdy;
    bit lj [];
    longint sd_a, sd_e, fs_a, fs_e;
    sb = sbits(); ns = nslots(); F = sb * ns;
    sd_err = 0; fs_err = 0; st_err = 0; fl_err = 0;
    sd_a = 0; sd_e = 0; fs_a = 0; fs_e = 0;
    exp_rdy = '1;
    for (int c = 0; c < NCH; c++) begin
      exp_ld[c] = 0; exp_ur[c] = 0; ld[c] = 0; ur[c] = 0;
      if (wrote[c]) exp_rdy[c] = 1'b0;
    end
    for (int s = 0; s < ns; s++) begin
      if (cf_mono != 0 && s % 2 == 1) ew[s] = ew[s-1];
      else if (wrote[s]) begin
        ew[s] = algn(wdata[s]); exp_ld[s] = 1; exp_rdy[s] = 1'b1;
      end else begin
        ew[s] = cf_rep != 0 ? algn(last_sent[s]) : 32'h0; exp_ur[s] = 1;
      end
    end
    lj = new[F];
    for (int p = 0; p < F; p++) lj[p] = ew[p / sb][31 - (p % sb)];
    for (int p = 0; p < F; p++) begin
      bit esd, efs;
      logic sd_s, fs_s;
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      esd = (cf_fmt % 2 == 1) ? lj[p] : (p == 0 ? prev_lj : lj[p-1]);
      if (cf_fmt < 2) efs = ((p / sb) % 2 == 1);
      else if (cf_fsw == 0) efs = (p < 32);
      else if (cf_fsw == 1) efs = (p < ns * 16);
      else efs = (p == 0);
      if (sd_out !== esd) begin if (sd_err == 0) begin sd_a = sd_out; sd_e = esd; end sd_err++; end
      if (fs_out !== efs) begin if (fs_err == 0) begin fs_a = fs_out; fs_e = efs; end fs_err++; end
      if (bit_stb !== 1'b1) st_err++;
      for (int c = 0; c < NCH; c++) begin ld[c] += ch_loaded[c]; ur[c] += ch_underrun[c]; end
      sd_s = sd_out; fs_s = fs_out;
      @(negedge clk);
      if (sd_out !== sd_s || fs_out !== fs_s || bit_stb !== 1'b0 ||
          ch_loaded !== '0 || ch_underrun !== '0) st_err++;
      if (midchange && p == F / 2) begin
        cfg_fmt = 2'd0; cfg_len = 3'd4; cfg_narrow = 1'b0;
      end
    end
    prev_lj = lj[F-1];
    chk(sd_err == 0, tsd, "serial data bits", sd_a, sd_e);
    chk(fs_err == 0, tfs, "frame sync bits", fs_a, fs_e);
    chk(st_err == 0, "R12", "strobe/hold errors", st_err, 0);
    for (int c = 0; c < NCH; c++)
      if (ld[c] != exp_ld[c] || ur[c] != exp_ur[c]) fl_err++;
    chk(fl_err == 0, "R8 R10", "channels with wrong loaded/underrun count", fl_err, 0);
    chk(s_ready == exp_rdy, "R9 R10", "ready after frame", s_ready, exp_rdy);
    for (int s = 0; s < ns; s++)
      if (exp_ld[s] == 1) begin last_sent[s] = wdata[s]; wrote[s] = 0; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_dut();
    chk(sd_out == 0 && fs_out == 0 && bit_stb == 0, "R1", "serial outputs", {sd_out, fs_out, bit_stb}, 0);
    chk(s_ready == '1, "R1", "ready", s_ready, '1);
    chk(ch_loaded == '0 && ch_underrun == '0, "R1", "flags", {ch_loaded, ch_underrun}, 0);

    // Sweep: every format, length code and narrow setting (R2 R3 R4 R5 R6 R7).
    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 8; l++)
        for (int n = 0; n < 2; n++) begin
          int sm1, mask;
          reset_dut();
          sm1 = (l + 3 * n) % 8;
          set_cfg(f, l, n, sm1, (l + n) % 4, 0, 0);
          mask = (1 << nslots()) - 1;
          write_ch(NCH'(mask), f * 16 + l * 2 + n);
          run_frame(0, f < 2 ? "R2 R3 R4" : "R2 R3 R5", f < 2 ? "R6" : "R7");
        end

    // Underrun fill policies, two-channel and TDM (R8).
    reset_dut();
    set_cfg(0, 4, 0, 0, 0, 0, 1);
    write_ch(8'h03, 100);
    run_frame(0, "R3", "R6");
    run_frame(0, "R8", "R6");
    set_cfg(0, 4, 0, 0, 0, 0, 0);
    run_frame(0, "R8", "R6");
    reset_dut();
    set_cfg(3, 1, 0, 3, 1, 0, 1);
    write_ch(8'h0F, 101);
    run_frame(0, "R5", "R7");
    write_ch(8'h05, 102);
    run_frame(0, "R8", "R7");

    // Mono duplication (R9).
    reset_dut();
    set_cfg(1, 1, 1, 0, 0, 1, 0);
    write_ch(8'h03, 103);
    run_frame(0, "R9", "R6");
    reset_dut();
    set_cfg(2, 0, 0, 4, 1, 1, 0);
    write_ch(8'h1F, 104);
    run_frame(0, "R9", "R7");

    // Configuration sampled at frame start only (R11).
    reset_dut();
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    write_ch(8'h03, 105);
    run_frame(1, "R11", "R11");
    set_cfg(0, 4, 0, 0, 0, 0, 0);
    write_ch(8'h03, 106);
    run_frame(0, "R11", "R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule